// File: doc/BRIEF.md
# Disciplined Oscillator Phase Loop

This block steers a voltage-controlled crystal oscillator so that its frequency matches a one-pulse-per-second reference from a satellite timing receiver. The block runs from a clock at twice the oscillator frequency. It synchronises the reference pulse into that clock and counts the clock cycles between successive rising edges. It turns the difference between that count and the nominal count into a signed phase error. A proportional-integral controller then converts the error into a 16-bit tuning word for an external DAC.

The controller has two gain sets. A wide-bandwidth set pulls the oscillator in quickly. A narrow set, with half the proportional gain and a quarter of the integral gain, is used once the error stays small, and it gives smoother tuning. Each update also reports the signed change of the tuning word on a logging strobe. The physical DAC is one bit narrower than the tuning word. The missing least significant bit is recovered by alternating the DAC code between two neighbouring values on every clock. When reference pulses stop, the tuning word is frozen and a flag is raised.

Top module: `gpsdo_pi_loop`

## Requirements
- R1: `pps_i` passes through a two-stage synchroniser, and only its rising edges count. The first rising edge after reset, and the first after a missing-pulse event, only starts a measurement and produces no update.
- R2: Let P be the number of clocks between two successive rising edges of `pps_i`. The update for that interval uses the whole-count error e = NOMINAL − P and the half-count error h = 2·e − 1. The −1 centres the count bins on the ideal alignment.
- R3: Each update raises `corr_valid_o` for exactly one clock. This happens on the third rising clock edge after the edge that first samples `pps_i` high.
- R4: The integrator holds a value I with 9 fractional bits. It resets to INIT_TUNE·512. On each update it becomes I + Ki·h, clamped to the range 0 to 65535·512.
- R5: On each update, `tune_o` becomes the value (I_new + Kp·h) shifted right arithmetically by 9 bits, clamped to 0…65535. I_new is the integrator value after that update. `tune_o` resets to INIT_TUNE and does not change between updates.
- R6: When `corr_valid_o` is high, `corr_o` equals the new `tune_o` minus the previous `tune_o`, as a 17-bit two's-complement value.
- R7: Gains are unsigned values with 8 fractional bits. The acquisition set is Kp = 853, Ki = 27. The tracking set is Kp = 427, Ki = 7. An update uses the set that was active before that update.
- R8: The loop starts in acquisition (`stable_o` = 0). It enters tracking after 16 consecutive updates with |e| ≤ 2. Any acquisition update with |e| > 2 restarts that run. In tracking, an update with |e| > 8 returns the loop to acquisition. Updates with |e| ≤ 8 keep it in tracking. `stable_o` changes only on update clocks.
- R9: Once armed, if the counter reaches TIMEOUT clocks with no new edge, `pps_missing_o` rises and no update follows. The next edge clears the flag and only re-arms the counter. A period of exactly TIMEOUT is still measured.
- R10: Let b = `tune_o`[15:1]. `dac_o` equals b + 1 when `tune_o`[0] is 1, the dither phase is 1 and b is below 32767; otherwise `dac_o` equals b. The dither phase is 0 in reset and inverts on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock, twice the oscillator frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pps_i | input | 1 | One-pulse-per-second reference, asynchronous |
| tune_o | output | 16 | Full-resolution tuning word |
| dac_o | output | 15 | Dithered code for the 15-bit DAC |
| corr_valid_o | output | 1 | One-clock strobe on each loop update |
| corr_o | output | 17 | Signed change of the tuning word at this update |
| stable_o | output | 1 | High while the tracking gain set is active |
| pps_missing_o | output | 1 | Reference pulse overdue |

## Verification
The reference pulse is driven with several patterns, and each one separates a different part of the loop. Exact nominal periods and small alternating offsets of ±1 and ±2 counts expose any error in the half-bin centring and in the integrator rounding. A single 15-count step separates the unlock threshold from the lock threshold. A 6-count step confirms that tracking survives errors inside the wider window. A gap longer than the timeout exercises the hold and re-arm sequence. A long run of slow periods drives both the integrator and the tuning word into the lower clamp, so saturation can be told apart from wrap-around. A final run of fast periods recovers from that clamp.

// File: rtl/gpsdo_pkg.sv
package gpsdo_pkg;
  typedef enum logic {
    GAIN_ACQ = 1'b0,
    GAIN_TRK = 1'b1
  } gain_mode_e;

  localparam int unsigned GAIN_FRAC = 8;
  localparam int unsigned GAIN_W    = 12;
endpackage

// File: rtl/gpsdo_pps_sync.sv
module gpsdo_pps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pps_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/gpsdo_phase_meas.sv
module gpsdo_phase_meas #(
  parameter int unsigned NOMINAL = 50_000_000,
  parameter int unsigned TIMEOUT = 75_000_000,
  parameter int unsigned CNT_W   = 27,
  parameter int unsigned ERR_W   = 30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rise_i,
  output logic                    meas_valid_o,
  output logic signed [ERR_W-1:0] err_cnt_o,
  output logic signed [ERR_W-1:0] err_half_o,
  output logic                    missing_o
);
  localparam logic signed [ERR_W-1:0] NOM_S = ERR_W'(NOMINAL);
  localparam logic [CNT_W-1:0]        TMO_C = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0]        cnt_q;
  logic                    armed_q;
  logic signed [ERR_W-1:0] diff;

  assign diff = NOM_S - $signed({{(ERR_W-CNT_W){1'b0}}, cnt_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      armed_q      <= 1'b0;
      missing_o    <= 1'b0;
      meas_valid_o <= 1'b0;
      err_cnt_o    <= '0;
      err_half_o   <= '0;
    end else begin
      meas_valid_o <= 1'b0;
      if (rise_i) begin
        cnt_q     <= CNT_W'(1);
        armed_q   <= 1'b1;
        missing_o <= 1'b0;
        if (armed_q) begin
          meas_valid_o <= 1'b1;
          err_cnt_o    <= diff;
          // shift bins by half a count: true interval is cnt + 0.5
          err_half_o   <= (diff <<< 1) - $signed(ERR_W'(1));
        end
      end else begin
        if (armed_q && cnt_q == TMO_C) begin
          missing_o <= 1'b1;
          armed_q   <= 1'b0;
        end
        if (cnt_q != TMO_C) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/gpsdo_gain_sched.sv
module gpsdo_gain_sched
  import gpsdo_pkg::*;
#(
  parameter int unsigned ERR_W      = 30,
  parameter int unsigned KP_ACQ     = 853,
  parameter int unsigned KI_ACQ     = 27,
  parameter int unsigned KP_TRK     = 427,
  parameter int unsigned KI_TRK     = 7,
  parameter int unsigned LOCK_RUN   = 16,
  parameter int unsigned LOCK_TOL   = 2,
  parameter int unsigned UNLOCK_TOL = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    meas_valid_i,
  input  logic signed [ERR_W-1:0] err_cnt_i,
  output gain_mode_e              mode_o,
  output logic [GAIN_W-1:0]       kp_o,
  output logic [GAIN_W-1:0]       ki_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

  logic [RUN_W-1:0] run_q;
  logic [ERR_W-1:0] err_mag;
  logic             near, far;

  assign err_mag = err_cnt_i[ERR_W-1] ? ERR_W'(-err_cnt_i) : ERR_W'(err_cnt_i);
  assign near    = err_mag <= ERR_W'(LOCK_TOL);
  assign far     = err_mag >  ERR_W'(UNLOCK_TOL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= GAIN_ACQ;
      run_q  <= '0;
    end else if (meas_valid_i) begin
      unique case (mode_o)
        GAIN_ACQ: begin
          if (!near) begin
            run_q <= '0;
          end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
            mode_o <= GAIN_TRK;
            run_q  <= '0;
          end else begin
            run_q <= run_q + RUN_W'(1);
          end
        end
        GAIN_TRK: begin
          if (far) begin
            mode_o <= GAIN_ACQ;
            run_q  <= '0;
          end
        end
        default: mode_o <= GAIN_ACQ;
      endcase
    end
  end

  assign kp_o = (mode_o == GAIN_TRK) ? GAIN_W'(KP_TRK) : GAIN_W'(KP_ACQ);
  assign ki_o = (mode_o == GAIN_TRK) ? GAIN_W'(KI_TRK) : GAIN_W'(KI_ACQ);
endmodule

// File: rtl/gpsdo_pi_core.sv
module gpsdo_pi_core
  import gpsdo_pkg::*;
#(
  parameter int unsigned ERR_W     = 30,
  parameter int unsigned DAC_W     = 16,
  parameter int unsigned INIT_TUNE = 32768
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    meas_valid_i,
  input  logic signed [ERR_W-1:0] err_half_i,
  input  logic [GAIN_W-1:0]       kp_i,
  input  logic [GAIN_W-1:0]       ki_i,
  output logic [DAC_W-1:0]        tune_o,
  output logic signed [DAC_W:0]   corr_o,
  output logic                    corr_valid_o
);
  // gain Q8 times half-count error gives Q9 in DAC LSB
  localparam int unsigned SH     = GAIN_FRAC + 1;
  localparam int unsigned PROD_W = ERR_W + GAIN_W + 1;
  localparam int unsigned I_W    = DAC_W + SH;
  localparam int unsigned SUM_W  = PROD_W + I_W + 2;
  localparam logic signed [SUM_W-1:0] I_MAX  = SUM_W'(((64'd1 << DAC_W) - 64'd1) << SH);
  localparam logic signed [SUM_W-1:0] T_MAX  = SUM_W'((64'd1 << DAC_W) - 64'd1);
  localparam logic [I_W-1:0]          I_INIT = I_W'(INIT_TUNE) << SH;

  logic [I_W-1:0]           integ_q;
  logic signed [PROD_W-1:0] err_ext, kp_ext, ki_ext, p_term, i_term;
  logic signed [SUM_W-1:0]  i_sum, i_new, t_sum, t_shift;
  logic [DAC_W-1:0]         t_new;
  logic signed [DAC_W:0]    corr_d;

  assign err_ext = PROD_W'(err_half_i);
  assign kp_ext  = $signed(PROD_W'(kp_i));
  assign ki_ext  = $signed(PROD_W'(ki_i));
  assign p_term  = kp_ext * err_ext;
  assign i_term  = ki_ext * err_ext;

  always_comb begin
    i_sum = $signed(SUM_W'(integ_q)) + SUM_W'(i_term);
    if (i_sum[SUM_W-1])     i_new = '0;
    else if (i_sum > I_MAX) i_new = I_MAX;
    else                    i_new = i_sum;

    t_sum   = i_new + SUM_W'(p_term);
    t_shift = t_sum >>> SH;
    if (t_shift[SUM_W-1])     t_new = '0;
    else if (t_shift > T_MAX) t_new = '1;
    else                      t_new = t_shift[DAC_W-1:0];
  end

  assign corr_d = $signed({1'b0, t_new}) - $signed({1'b0, tune_o});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q      <= I_INIT;
      tune_o       <= DAC_W'(INIT_TUNE);
      corr_o       <= '0;
      corr_valid_o <= 1'b0;
    end else begin
      corr_valid_o <= meas_valid_i;
      if (meas_valid_i) begin
        integ_q <= i_new[I_W-1:0];
        tune_o  <= t_new;
        corr_o  <= corr_d;
      end
    end
  end
endmodule

// File: rtl/gpsdo_dither.sv
module gpsdo_dither #(
  parameter int unsigned DAC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DAC_W-1:0] tune_i,
  output logic [DAC_W-2:0] dac_o
);
  logic             ph_q;
  logic [DAC_W-2:0] base;
  logic             bump;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign base  = tune_i[DAC_W-1:1];
  // at full scale the upper code is unreachable, so no bump
  assign bump  = tune_i[0] & ph_q & ~(&base);
  assign dac_o = base + (DAC_W-1)'(bump);
endmodule

// File: rtl/gpsdo_pi_loop.sv
module gpsdo_pi_loop
  import gpsdo_pkg::*;
#(
  parameter int unsigned NOMINAL     = 50_000_000,
  parameter int unsigned TIMEOUT     = 75_000_000,
  parameter int unsigned INIT_TUNE   = 32768,
  parameter int unsigned DAC_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned KP_ACQ      = 853,
  parameter int unsigned KI_ACQ      = 27,
  parameter int unsigned KP_TRK      = 427,
  parameter int unsigned KI_TRK      = 7,
  parameter int unsigned LOCK_RUN    = 16,
  parameter int unsigned LOCK_TOL    = 2,
  parameter int unsigned UNLOCK_TOL  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pps_i,
  output logic [DAC_W-1:0]      tune_o,
  output logic [DAC_W-2:0]      dac_o,
  output logic                  corr_valid_o,
  output logic signed [DAC_W:0] corr_o,
  output logic                  stable_o,
  output logic                  pps_missing_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam int unsigned ERR_W = CNT_W + 3;

  logic                    rise;
  logic                    meas_valid;
  logic signed [ERR_W-1:0] err_cnt, err_half;
  gain_mode_e              mode;
  logic [GAIN_W-1:0]       kp, ki;

  gpsdo_pps_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pps_i (pps_i),
    .rise_o(rise)
  );

  gpsdo_phase_meas #(
    .NOMINAL(NOMINAL),
    .TIMEOUT(TIMEOUT),
    .CNT_W  (CNT_W),
    .ERR_W  (ERR_W)
  ) i_meas (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .meas_valid_o(meas_valid),
    .err_cnt_o   (err_cnt),
    .err_half_o  (err_half),
    .missing_o   (pps_missing_o)
  );

  gpsdo_gain_sched #(
    .ERR_W     (ERR_W),
    .KP_ACQ    (KP_ACQ),
    .KI_ACQ    (KI_ACQ),
    .KP_TRK    (KP_TRK),
    .KI_TRK    (KI_TRK),
    .LOCK_RUN  (LOCK_RUN),
    .LOCK_TOL  (LOCK_TOL),
    .UNLOCK_TOL(UNLOCK_TOL)
  ) i_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .meas_valid_i(meas_valid),
    .err_cnt_i   (err_cnt),
    .mode_o      (mode),
    .kp_o        (kp),
    .ki_o        (ki)
  );

  gpsdo_pi_core #(
    .ERR_W    (ERR_W),
    .DAC_W    (DAC_W),
    .INIT_TUNE(INIT_TUNE)
  ) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .meas_valid_i(meas_valid),
    .err_half_i  (err_half),
    .kp_i        (kp),
    .ki_i        (ki),
    .tune_o      (tune_o),
    .corr_o      (corr_o),
    .corr_valid_o(corr_valid_o)
  );

  gpsdo_dither #(.DAC_W(DAC_W)) i_dither (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tune_i(tune_o),
    .dac_o (dac_o)
  );

  assign stable_o = (mode == GAIN_TRK);
endmodule

// File: rtl/gpsdo_pi_loop_chk.sv
module gpsdo_pi_loop_chk #(
  parameter int unsigned DAC_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [DAC_W-1:0]      tune_o,
  input logic [DAC_W-2:0]      dac_o,
  input logic                  corr_valid_o,
  input logic signed [DAC_W:0] corr_o,
  input logic                  stable_o,
  input logic                  pps_missing_o
);
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |=> !corr_valid_o); // R3

  AST_TUNE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_valid_o |-> $stable(tune_o)); // R5

  AST_CORR_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> (corr_o == ($signed({1'b0, tune_o}) - $signed({1'b0, $past(tune_o)})))); // R6

  AST_MODE_ON_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stable_o != $past(stable_o)) |-> corr_valid_o); // R8

  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_missing_o |-> !corr_valid_o); // R9

  AST_DITHER_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tune_o[0] |-> (dac_o == tune_o[DAC_W-1:1])); // R10

  AST_DITHER_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_o == tune_o[DAC_W-1:1]) || (dac_o == tune_o[DAC_W-1:1] + (DAC_W-1)'(1))); // R10
endmodule

bind gpsdo_pi_loop gpsdo_pi_loop_chk #(.DAC_W(DAC_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tune_o       (tune_o),
  .dac_o        (dac_o),
  .corr_valid_o (corr_valid_o),
  .corr_o       (corr_o),
  .stable_o     (stable_o),
  .pps_missing_o(pps_missing_o)
);

// File: tb/test_gpsdo_pi_loop.sv
module test_gpsdo_pi_loop;
  localparam int NOM  = 200;
  localparam int TMO  = 300;
  localparam int INIT = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps = 1'b0;
  logic [15:0] tune;
  logic [14:0] dac;
  logic        cvalid;
  logic signed [16:0] corr;
  logic        stable;
  logic        missing;

  always #5 clk = ~clk;

  gpsdo_pi_loop #(
    .NOMINAL  (NOM),
    .TIMEOUT  (TMO),
    .INIT_TUNE(INIT)
  ) i_gpsdo_pi_loop (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pps_i        (pps),
    .tune_o       (tune),
    .dac_o        (dac),
    .corr_valid_o (cvalid),
    .corr_o       (corr),
    .stable_o     (stable),
    .pps_missing_o(missing)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  task automatic chk(input longint act, input longint exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  longint m_s1, m_s2, m_s3, m_cnt, m_e, m_h, m_run, m_integ, m_tune, m_corr;
  bit     m_armed, m_miss, m_mv, m_val, m_trk, m_ph;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_e = 0; m_h = 0; m_run = 0;
      m_integ = longint'(INIT) * 512; m_tune = INIT; m_corr = 0;
      m_armed = 0; m_miss = 0; m_mv = 0; m_val = 0; m_trk = 0; m_ph = 0;
    end else begin
      longint kp, ki, isum, tsum, tsh, mag;
      m_val = m_mv;
      if (m_mv) begin
        kp = m_trk ? 427 : 853;
        ki = m_trk ? 7 : 27;
        isum = m_integ + ki * m_h;
        if (isum < 0) isum = 0;
        if (isum > 65535 * 512) isum = 65535 * 512;
        tsum = isum + kp * m_h;
        tsh = tsum >>> 9;
        if (tsh < 0) tsh = 0;
        if (tsh > 65535) tsh = 65535;
        m_corr = tsh - m_tune;
        m_tune = tsh;
        m_integ = isum;
        mag = (m_e < 0) ? -m_e : m_e;
        if (!m_trk) begin
          if (mag <= 2) begin
            if (m_run == 15) begin m_trk = 1; m_run = 0; end
            else m_run = m_run + 1;
          end else m_run = 0;
        end else if (mag > 8) begin
          m_trk = 0; m_run = 0;
        end
      end
      m_ph = !m_ph;
      m_mv = 0;
      if (m_s2 == 1 && m_s3 == 0) begin
        if (m_armed) begin
          m_mv = 1;
          m_e = NOM - m_cnt;
          m_h = 2 * m_e - 1;
        end
        m_armed = 1; m_miss = 0; m_cnt = 1;
      end else begin
        if (m_armed && m_cnt == TMO) begin m_miss = 1; m_armed = 0; end
        if (m_cnt != TMO) m_cnt = m_cnt + 1;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = longint'(pps);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      longint base, edac;
      base = m_tune >>> 1;
      edac = base + (((m_tune % 2) == 1 && m_ph && base != 32767) ? 1 : 0);
      chk(longint'(cvalid), longint'(m_val), "R1 R3 corr_valid_o");
      chk(longint'(tune), m_tune, "R2 R5 R7 tune_o");
      chk(longint'(dac), edac, "R10 dac_o");
      chk(longint'(stable), longint'(m_trk), "R8 stable_o");
      chk(longint'(missing), longint'(m_miss), "R9 pps_missing_o");
      if (cvalid) chk(longint'(corr), m_corr, "R6 corr_o");
    end
  end

  task automatic send(input int p);
    @(negedge clk) pps = 1'b1;
    repeat (5) @(negedge clk);
    pps = 1'b0;
    repeat (p - 6) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog: actual running expected finished at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(longint'(tune), INIT, "R5 reset tune_o");
    chk(longint'(cvalid), 0, "R3 reset corr_valid_o");
    chk(longint'(stable), 0, "R8 reset stable_o");
    chk(longint'(missing), 0, "R9 reset pps_missing_o");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // first edge only arms (R1), then nominal and small offsets
    repeat (3) send(NOM);
    for (int i = 0; i < 20; i++) send(NOM + (i % 5) - 2);
    chk(longint'(stable), 1, "R8 lock after run of small errors");

    send(NOM + 15);
    send(NOM);
    chk(longint'(stable), 0, "R8 unlock on large error");

    for (int i = 0; i < 18; i++) send(NOM + 1);
    chk(longint'(stable), 1, "R8 relock");

    send(NOM + 6);
    send(NOM);
    chk(longint'(stable), 1, "R8 mid error keeps tracking");

    // reference gap longer than the timeout
    @(negedge clk) pps = 1'b1;
    repeat (5) @(negedge clk);
    pps = 1'b0;
    repeat (344) @(negedge clk);
    chk(longint'(missing), 1, "R9 flag during gap");
    repeat (50) @(negedge clk);
    repeat (3) send(NOM);
    chk(longint'(missing), 0, "R9 flag cleared");

    // slow oscillator drives integrator and word into lower clamp
    for (int i = 0; i < 40; i++) send(NOM + 80);
    chk(longint'(tune), 0, "R4 R5 lower clamp");
    for (int i = 0; i < 6; i++) send(NOM - 50);
    repeat (10) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule